// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device side of a small three-wire serial EEPROM, written as synthesizable logic that runs on a system clock. A host drives a chip select, a serial clock and a data line. The block answers on a serial data output that has its own output enable. The serial inputs are sampled in the system clock domain, so the serial clock must run several times slower than the system clock. The storage holds 2048 bits. It is seen either as 128 words of 16 bits or as 256 bytes. A static organization input chooses between the two views.

A command is a start bit, then an opcode, then an address, and after some commands a data word. A read answers at once with a leading zero and then the addressed word. Write, erase, write-all and erase-all are only queued while the command is shifted in. They take effect through a self-timed program cycle that starts when chip select falls. While that cycle runs, the host can raise chip select and poll the output line to see whether the device is busy or ready. A parameter sets the length of the program cycle in system clock cycles.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the output enable is low and the device is write-locked. Reset does not clear the stored contents.
- R2: On the serial clock rising edge that delivers the last address bit of a read (opcode 10), the output is enabled and shows a 0. Each later rising edge shifts out the next bit of the addressed word, MSB first.
- R3: After a write-enable, a write (opcode 01 plus address plus data) is stored in the addressed word once chip select falls and the program cycle has ended.
- R4: While the device is locked, write, erase, write-all and erase-all have no effect. Opcode 00 with address MSBs 11 unlocks the device and address MSBs 00 locks it again.
- R5: An erase (opcode 11) sets every bit of the addressed word to 1.
- R6: Opcode 00 with address MSBs 10 sets every word to all ones. Address MSBs 01 followed by a data word writes that word to every location.
- R7: While a program cycle runs, a raised chip select with no start bit enables the output at 0. It shows 1 once the cycle has ended.
- R8: Every bit received while a program cycle runs is ignored, including start bits.
- R9: Zeros that come before the start bit are ignored.
- R10: If chip select falls before a command is complete, the command has no effect.
- R11: With the organization input low, addresses are 8 bits and data is 8 bits. Byte address a maps to word a>>1, the upper half when bit 0 is 1 and the lower half when it is 0. With the input high, addresses are 7 bits and data is 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock; input bits are taken on its rising edge |
| di_i | input | 1 | Serial data in |
| wide_org_i | input | 1 | Organization: 1 selects 16-bit words, 0 selects bytes |
| do_o | output | 1 | Serial data out |
| do_en_o | output | 1 | Output enable for do_o (high drives the line) |

## Verification
The bench checks the leading zero of a read. A design that leaves it out shifts every word one bit early. A lock test shows that a write after a lock command, or after reset, leaves the old word in place. A design that resets to unlocked or ignores the lock would overwrite it. A full write command is sent during a busy period, and a write is cut short by chip select. A design that did not ignore the first or did not abort the second would corrupt the target word. Byte writes are read back as a whole 16-bit word, which exposes a swapped half or a wrong address shift in byte mode.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADR,
    ST_DIN,
    ST_DOUT,
    ST_HOLD
  } mw_st_e;

  typedef enum logic [2:0] {
    PG_NONE,
    PG_WRITE,
    PG_ERASE,
    PG_CLRALL,
    PG_SETALL
  } mw_pg_e;

  localparam logic [1:0] OPC_EXT   = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_FILL   = 2'b01;
  localparam logic [1:0] EXT_WIPE   = 2'b10;
  localparam logic [1:0] EXT_UNLOCK = 2'b11;

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  output logic cs_o,
  output logic di_o,
  output logic rise_o,
  output logic cs_fall_o
);

  logic cs_q, cs_d, sclk_q, sclk_d, di_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      cs_d   <= 1'b0;
      sclk_q <= 1'b0;
      sclk_d <= 1'b0;
      di_q   <= 1'b0;
    end else begin
      cs_q   <= cs_i;
      cs_d   <= cs_q;
      sclk_q <= sclk_i;
      sclk_d <= sclk_q;
      di_q   <= di_i;
    end
  end

  assign cs_o      = cs_q;
  assign di_o      = di_q;
  assign rise_o    = sclk_q & ~sclk_d;
  assign cs_fall_o = cs_d & ~cs_q;

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);

  logic             busy_q, busy_n, done_q, done_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    if (start_i) begin
      busy_n = 1'b1;
      cnt_n  = '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
      cnt_q  <= cnt_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q); // R8
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CNT_W'(PROG_CYCLES))); // R3

endmodule

// File: rtl/mw_cell_array.sv
module mw_cell_array
  import mw_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NWORDS = 128
) (
  input  logic                 clk,
  input  logic                 commit_i,
  input  mw_pg_e               op_i,
  input  logic                 wide_i,
  input  logic [$clog2(NWORDS):0] addr_i,
  input  logic [WORD_W-1:0]    data_i,
  input  logic                 rwide_i,
  input  logic [$clog2(NWORDS):0] raddr_i,
  output logic [WORD_W-1:0]    rdata_o
);

  localparam int WADR_W = $clog2(NWORDS);
  localparam int BADR_W = WADR_W + 1;
  localparam int HALF_W = WORD_W / 2;

  logic [NWORDS*WORD_W-1:0] flat;
  logic [WADR_W-1:0]        widx, ridx;
  logic [WORD_W-1:0]        val, mask, rword;
  logic                     all_hit, clear;

  always_comb begin
    all_hit = (op_i == PG_CLRALL) || (op_i == PG_SETALL);
    clear   = (op_i == PG_ERASE) || (op_i == PG_CLRALL);
    widx    = wide_i ? addr_i[WADR_W-1:0] : addr_i[BADR_W-1:1];
    if (clear)       val = '1;
    else if (wide_i) val = data_i;
    else             val = {2{data_i[HALF_W-1:0]}};
    if (wide_i || all_hit) mask = '1;
    else if (addr_i[0])    mask = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
    else                   mask = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (commit_i && (all_hit || (widx == WADR_W'(g)))) begin
        word_q <= (word_q & ~mask) | (val & mask);
      end
    end
    assign flat[g*WORD_W +: WORD_W] = word_q;
  end

  always_comb begin
    ridx  = rwide_i ? raddr_i[WADR_W-1:0] : raddr_i[BADR_W-1:1];
    rword = flat[int'(ridx)*WORD_W +: WORD_W];
    if (rwide_i)         rdata_o = rword;
    else if (raddr_i[0]) rdata_o = {rword[WORD_W-1:HALF_W], {HALF_W{1'b0}}};
    else                 rdata_o = {rword[HALF_W-1:0], {HALF_W{1'b0}}};
  end

  AST_COMMIT_KNOWN_OP: assert property (@(posedge clk)
    commit_i |-> (op_i != PG_NONE)); // R3

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int NWORDS      = 128,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic di_i,
  input  logic wide_org_i,
  output logic do_o,
  output logic do_en_o
);

  localparam int WADR_W = $clog2(NWORDS);
  localparam int BADR_W = WADR_W + 1;
  localparam int HALF_W = WORD_W / 2;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  // reset: asserted asynchronously, released through two flops
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic cs_s, di_s, rise, cs_fall;
  mw_pin_sync u_pins (
    .clk       (clk),
    .rst_n     (rst_s),
    .cs_i      (cs_i),
    .sclk_i    (sclk_i),
    .di_i      (di_i),
    .cs_o      (cs_s),
    .di_o      (di_s),
    .rise_o    (rise),
    .cs_fall_o (cs_fall)
  );

  logic go, busy, done;
  mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_s),
    .start_i (go),
    .busy_o  (busy),
    .done_o  (done)
  );

  mw_st_e            st_q, st_n;
  mw_pg_e            pend_q, pend_n, p_op_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n, alen, dlen;
  logic [1:0]        opc_q, opc_n, ext;
  logic [BADR_W-1:0] adr_q, adr_n, adr_full, p_adr_q;
  logic [WORD_W-1:0] dat_q, dat_n, sh_q, sh_n, p_dat_q, rdata;
  logic              dout_q, dout_n, oe_q, oe_n, wen_q, wen_n, stat_q, stat_n;
  logic              p_wide_q;

  mw_cell_array #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_cells (
    .clk      (clk),
    .commit_i (done),
    .op_i     (p_op_q),
    .wide_i   (p_wide_q),
    .addr_i   (p_adr_q),
    .data_i   (p_dat_q),
    .rwide_i  (wide_org_i),
    .raddr_i  (adr_full),
    .rdata_o  (rdata)
  );

  always_comb begin
    alen     = wide_org_i ? CNT_W'(WADR_W) : CNT_W'(BADR_W);
    dlen     = wide_org_i ? CNT_W'(WORD_W) : CNT_W'(HALF_W);
    adr_full = {adr_q[BADR_W-2:0], di_s};
    ext      = wide_org_i ? adr_full[WADR_W-1 -: 2] : adr_full[BADR_W-1 -: 2];
  end

  always_comb begin
    st_n = st_q;   cnt_n = cnt_q;   opc_n = opc_q;  adr_n = adr_q;
    dat_n = dat_q; sh_n = sh_q;     dout_n = dout_q; oe_n = oe_q;
    wen_n = wen_q; pend_n = pend_q; stat_n = stat_q; go = 1'b0;
    if (cs_fall) begin
      st_n   = ST_IDLE;
      cnt_n  = '0;
      oe_n   = 1'b0;
      dout_n = 1'b0;
      go     = (st_q == ST_HOLD) && (pend_q != PG_NONE) && wen_q;
      pend_n = PG_NONE;
      stat_n = go | (stat_q & busy);
    end else if (cs_s) begin
      if (st_q == ST_IDLE && stat_q) begin
        oe_n   = 1'b1;
        dout_n = !busy;
      end
      if (rise) begin
        unique case (st_q)
          ST_IDLE: begin
            if (di_s && !busy) begin
              st_n   = ST_OPC;
              cnt_n  = '0;
              stat_n = 1'b0;
              oe_n   = 1'b0;
              dout_n = 1'b0;
              adr_n  = '0;
            end
          end
          ST_OPC: begin
            opc_n = {opc_q[0], di_s};
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(1)) begin
              st_n  = ST_ADR;
              cnt_n = '0;
            end
          end
          ST_ADR: begin
            adr_n = adr_full;
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == alen - 1'b1) begin
              cnt_n = '0;
              st_n  = ST_HOLD;
              unique case (opc_q)
                OPC_READ: begin
                  st_n   = ST_DOUT;
                  sh_n   = rdata;
                  oe_n   = 1'b1;
                  dout_n = 1'b0;
                end
                OPC_WRITE: st_n = ST_DIN;
                OPC_ERASE: pend_n = PG_ERASE;
                default: begin
                  unique case (ext)
                    EXT_UNLOCK: wen_n  = 1'b1;
                    EXT_LOCK:   wen_n  = 1'b0;
                    EXT_WIPE:   pend_n = PG_CLRALL;
                    default:    st_n   = ST_DIN;
                  endcase
                end
              endcase
            end
          end
          ST_DIN: begin
            dat_n = {dat_q[WORD_W-2:0], di_s};
            cnt_n = cnt_q + 1'b1;
            if (cnt_q == dlen - 1'b1) begin
              st_n   = ST_HOLD;
              pend_n = (opc_q == OPC_WRITE) ? PG_WRITE : PG_SETALL;
            end
          end
          ST_DOUT: begin
            dout_n = sh_q[WORD_W-1];
            sh_n   = {sh_q[WORD_W-2:0], 1'b0};
            cnt_n  = cnt_q + 1'b1;
            if (cnt_q == dlen - 1'b1) st_n = ST_HOLD;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      opc_q  <= '0;
      adr_q  <= '0;
      dat_q  <= '0;
      sh_q   <= '0;
      dout_q <= 1'b0;
      oe_q   <= 1'b0;
      wen_q  <= 1'b0;
      pend_q <= PG_NONE;
      stat_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      opc_q  <= opc_n;
      adr_q  <= adr_n;
      dat_q  <= dat_n;
      sh_q   <= sh_n;
      dout_q <= dout_n;
      oe_q   <= oe_n;
      wen_q  <= wen_n;
      pend_q <= pend_n;
      stat_q <= stat_n;
    end
  end

  // program request held for the whole self-timed cycle
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      p_op_q   <= PG_NONE;
      p_adr_q  <= '0;
      p_dat_q  <= '0;
      p_wide_q <= 1'b1;
    end else if (go) begin
      p_op_q   <= pend_q;
      p_adr_q  <= adr_q;
      p_dat_q  <= dat_q;
      p_wide_q <= wide_org_i;
    end
  end

  assign do_o    = dout_q;
  assign do_en_o = oe_q;

  AST_LOCKED_NO_PROG: assert property (@(posedge clk) disable iff (!rst_s)
    go |-> wen_q); // R4
  AST_BUSY_SHOWS_LOW: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && oe_q && st_q == ST_IDLE) |-> !dout_q); // R7
  AST_DUMMY_FIRST: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_DOUT && $past(st_q) != ST_DOUT) |-> (oe_q && !dout_q)); // R2
  AST_ABORT_NO_PROG: assert property (@(posedge clk) disable iff (!rst_s)
    (cs_fall && st_q != ST_HOLD) |-> !go); // R10
  AST_RELEASE_LINE: assert property (@(posedge clk) disable iff (!rst_s)
    cs_fall |=> !oe_q); // R1

endmodule

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;

  localparam int CLK_PERIOD = 10;
  localparam int PROG       = 200;

  logic clk, rst_n, cs, sclk, di, wide;
  logic dout, dout_en;

  mw_eeprom #(.WORD_W(16), .NWORDS(128), .PROG_CYCLES(PROG)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_i       (cs),
    .sclk_i     (sclk),
    .di_i       (di),
    .wide_org_i (wide),
    .do_o       (dout),
    .do_en_o    (dout_en)
  );

  typedef struct {
    logic [16:0] val;
    string       tag;
  } item_t;

  item_t       exp_q[$];
  logic [16:0] cap;
  event        cap_ev;
  int          checks = 0;
  int          fails  = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [16:0] act, input logic [16:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(cap_ev);
      if (exp_q.size() == 0) begin
        check(cap, 17'h1ffff, "monitor-empty");
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(cap, it.val, it.tag);
      end
    end
  end

  task automatic bitx(input logic b);
    @(negedge clk); sclk = 1'b0; di = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_up();
    @(negedge clk); cs = 1'b1; sclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk); cs = 1'b0; sclk = 1'b0; di = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic header(input logic [1:0] opc, input logic [7:0] a, input int alen);
    bitx(1'b1);
    bitx(opc[1]); bitx(opc[0]);
    for (int i = alen - 1; i >= 0; i--) bitx(a[i]);
  endtask

  task automatic data_bits(input logic [15:0] d, input int dlen);
    for (int i = dlen - 1; i >= 0; i--) bitx(d[i]);
  endtask

  function automatic int alen_f(); return wide ? 7 : 8; endfunction
  function automatic int dlen_f(); return wide ? 16 : 8; endfunction
  function automatic logic [7:0] ext_f(input logic [1:0] e);
    return wide ? {1'b0, e, 5'b0} : {e, 6'b0};
  endfunction

  task automatic wait_ready();
    repeat (PROG + 20) @(negedge clk);
  endtask

  task automatic unlock();
    cs_up(); header(2'b00, ext_f(2'b11), alen_f()); cs_down();
  endtask

  task automatic lock();
    cs_up(); header(2'b00, ext_f(2'b00), alen_f()); cs_down();
  endtask

  task automatic write(input logic [7:0] a, input logic [15:0] d, input int lead);
    cs_up();
    for (int i = 0; i < lead; i++) bitx(1'b0);
    header(2'b01, a, alen_f());
    data_bits(d, dlen_f());
    cs_down();
    wait_ready();
  endtask

  // driver side: push expected, then clock out the answer
  task automatic read(input logic [7:0] a, input logic [15:0] exp, input string tag);
    item_t it;
    int n;
    n = dlen_f();
    it.val = wide ? {1'b0, exp} : {9'b0, exp[7:0]};
    it.tag = tag;
    exp_q.push_back(it);
    cap = '0;
    cs_up();
    header(2'b10, a, alen_f());
    for (int i = 0; i <= n; i++) begin
      @(negedge clk); sclk = 1'b0;
      repeat (2) @(negedge clk);
      cap = {cap[15:0], dout};
      sclk = 1'b1;
      repeat (2) @(negedge clk);
    end
    ->cap_ev;
    cs_down();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cs = 1'b0; sclk = 1'b0; di = 1'b0; wide = 1'b1; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({16'b0, dout_en}, 17'd0, "R1 output disabled after reset");

    unlock();
    write(8'd3, 16'hBEEF, 0);
    read(8'd3, 16'hBEEF, "R3 write then read");

    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    write(8'd3, 16'h1111, 0);
    read(8'd3, 16'hBEEF, "R1 locked and contents kept after reset");

    unlock();
    write(8'd10, 16'hA5C3, 0);
    read(8'd10, 16'hA5C3, "R2 dummy zero then MSB first");
    lock();
    write(8'd10, 16'h0000, 0);
    read(8'd10, 16'hA5C3, "R4 write ignored after lock");
    unlock();

    // R7 status polling during a program cycle
    cs_up(); header(2'b01, 8'd20, 7); data_bits(16'h1234, 16); cs_down();
    cs_up(); repeat (4) @(negedge clk);
    check({15'b0, dout_en, dout}, 17'b10, "R7 busy shows enabled low");
    repeat (PROG + 10) @(negedge clk);
    check({15'b0, dout_en, dout}, 17'b11, "R7 ready shows enabled high");
    cs_down();
    read(8'd20, 16'h1234, "R3 word stored after status poll");

    // R8 a full command during busy is dropped
    cs_up(); header(2'b01, 8'd30, 7); data_bits(16'h5555, 16); cs_down();
    cs_up(); header(2'b01, 8'd30, 7); data_bits(16'h0F0F, 16); cs_down();
    wait_ready();
    read(8'd30, 16'h5555, "R8 command while busy ignored");

    write(8'd40, 16'h7E81, 3);
    read(8'd40, 16'h7E81, "R9 leading zeros ignored");

    cs_up(); header(2'b01, 8'd40, 7); data_bits(16'h00FF, 8); cs_down();
    wait_ready();
    read(8'd40, 16'h7E81, "R10 aborted write has no effect");

    cs_up(); header(2'b11, 8'd10, 7); cs_down(); wait_ready();
    read(8'd10, 16'hFFFF, "R5 erase gives all ones");

    cs_up(); header(2'b00, ext_f(2'b01), 7); data_bits(16'h2468, 16); cs_down();
    wait_ready();
    read(8'd3, 16'h2468, "R6 write-all low word");
    read(8'd127, 16'h2468, "R6 write-all top word");
    cs_up(); header(2'b00, ext_f(2'b10), 7); cs_down(); wait_ready();
    read(8'd3, 16'hFFFF, "R6 erase-all low word");
    read(8'd64, 16'hFFFF, "R6 erase-all mid word");

    // R11 byte organization
    wide = 1'b0;
    repeat (2) @(negedge clk);
    unlock();
    write(8'd9, 16'h005A, 0);
    write(8'd8, 16'h00C3, 0);
    read(8'd9, 16'h005A, "R11 byte read odd address");
    read(8'd8, 16'h00C3, "R11 byte read even address");
    wide = 1'b1;
    repeat (2) @(negedge clk);
    read(8'd4, 16'h5AC3, "R11 byte halves in word");

    repeat (10) @(negedge clk);
    check(exp_q.size(), 0, "R2 scoreboard drained");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule